// File: doc/BRIEF.md
# Management Bus Command Master

This block lets a host processor run single transactions on an on-chip management bus. The host sees four 32-bit registers: a command/status word, a write-data word, a timeout count and a read-data word. Writing a command word with its launch bit set starts one read or write to an addressed slave unit. The host then polls the command word until the launch bit drops, and finds the outcome in two sticky error flags in that same word.

On the bus side the block raises a request and holds it, with direction, slave address, word offset and write data steady, until the slave answers with an acknowledge or an error, or until the programmed wait runs out. A read that is acknowledged stores the returned data in the read-data register. An error or a timeout leaves that register as it was. Only one transaction is ever in flight. Commands and register writes that arrive meanwhile are dropped.

Top module: `mbm_master`

## Requirements
- R1: After reset all four host registers read 0 and the bus request is low.
- R2: A host write to offset 0x00 with bit 31 set, made while idle, raises bus_req on the next cycle with bus_we = bit 20 (1 write, 0 read), bus_addr = bits 19:12, bus_off = bits 11:0 and bus_wdata = the write-data register (offset 0x04). While running, the command word reads with bit 31 (START) and bit 28 (BUSY) both 1.
- R3: While waiting, bus_req, bus_we, bus_addr, bus_off and bus_wdata stay unchanged from cycle to cycle.
- R4: When bus_ack or bus_err is sampled high with the request up, bus_req, START and BUSY are all 0 from the next cycle. The request stays up for exactly the number of cycles up to and including the answering one.
- R5: An acknowledged read stores bus_rdata in the read-data register (offset 0x0C). An acknowledged write leaves that register unchanged.
- R6: An error answer sets bit 29 of the command word, leaves bit 30 clear and leaves the read-data register unchanged.
- R7: With a timeout value T > 0 (offset 0x08, in clock cycles), a transaction with no answer keeps the request up for exactly T cycles, then drops it and sets bit 30. An answer in the T-th cycle still completes normally.
- R8: A timeout value of 0 disables the timeout, so the request stays up until an answer arrives.
- R9: While BUSY is set, host writes to the command, write-data and timeout registers are ignored.
- R10: Both error flags stay set until the next launch, which clears them both.
- R11: A command-word write with bit 31 clear launches nothing and changes neither the flags nor the command fields shown at bits 20:0. Host writes to offset 0x0C are ignored. host_addr bits 1:0 are not decoded.
- R12: The write-data and timeout registers read back the last value written to them while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host byte offset, bits 3:2 decoded |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Selected register value (combinational) |
| bus_req | output | 1 | Transaction request to slave |
| bus_we | output | 1 | Direction, 1 = write |
| bus_addr | output | 8 | Slave unit address |
| bus_off | output | 12 | Word offset inside slave |
| bus_wdata | output | 32 | Data for write transactions |
| bus_ack | input | 1 | Slave success answer |
| bus_err | input | 1 | Slave error answer |
| bus_rdata | input | 32 | Slave read return data |

## Verification
On every cycle the assertions check that a launch raises the request, that the request and its fields hold until an answer or expiry, that an answer or expiry ends the transaction and sets the correct flag, that the flags and the write-data and timeout registers cannot move while they must not, and that the read-data register changes only on a capture. Only the bench scenarios can show the exact request length against the timeout value and the answer delay, the bit layout of the command word as seen by the host, and the read-data value after a sweep over slave addresses, offsets, directions and delays. They also show that commands issued while busy never reach the bus.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

  localparam int DW    = 32;
  localparam int SA_W  = 8;
  localparam int OFF_W = 12;

  // host register select (host_addr[3:2])
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_WDATA = 2'd1;
  localparam logic [1:0] SEL_TMO   = 2'd2;
  localparam logic [1:0] SEL_RDATA = 2'd3;

  // command word bit positions
  localparam int B_START = 31;
  localparam int B_TOUT  = 30;
  localparam int B_SERR  = 29;
  localparam int B_BUSY  = 28;
  localparam int B_DIR   = 20;
  localparam int B_SA_LO = 12;

  typedef struct packed {
    logic             we;
    logic [SA_W-1:0]  sa;
    logic [OFF_W-1:0] off;
  } mbm_cmd_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} mbm_state_t;

  function automatic mbm_cmd_t cmd_decode(input logic [DW-1:0] w);
    mbm_cmd_t c;
    c.we  = w[B_DIR];
    c.sa  = w[B_SA_LO +: SA_W];
    c.off = w[OFF_W-1:0];
    return c;
  endfunction

  function automatic logic [DW-1:0] ctrl_word(input logic start, input logic tout,
                                              input logic serr, input logic busy,
                                              input mbm_cmd_t c);
    logic [DW-1:0] w;
    w = '0;
    w[B_START] = start;
    w[B_TOUT]  = tout;
    w[B_SERR]  = serr;
    w[B_BUSY]  = busy;
    w[B_DIR]   = c.we;
    w[B_SA_LO +: SA_W] = c.sa;
    w[OFF_W-1:0] = c.off;
    return w;
  endfunction

  function automatic logic [1:0] reg_sel(input logic [3:0] byte_addr);
    return byte_addr[3:2];
  endfunction

endpackage

// File: rtl/mbm_timer.sv
module mbm_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMO_W-1:0] tmo_val,
  input  logic             run,
  input  logic             resp,
  output logic             expire
);

  localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

  logic [TMO_W-1:0] cnt_q;
  logic             armed_q;

  assign expire = run && armed_q && !resp && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      cnt_q   <= tmo_val;
      armed_q <= |tmo_val;
    end else if (run && armed_q && !resp && !expire) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // R7: an armed count never reaches zero while waiting
  p_cnt_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run && armed_q |-> cnt_q != '0);

  // R7: expiry ends the wait on the next cycle
  p_expire_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !run);

endmodule

// File: rtl/mbm_regs.sv
module mbm_regs
  import mbm_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [1:0]       host_sel,
  input  logic [DW-1:0]    host_wdata,
  input  logic             busy,
  input  logic             rd_capture,
  input  logic [DW-1:0]    rd_value,
  input  logic [DW-1:0]    ctrl_rb,
  output logic [DW-1:0]    wdata_q,
  output logic [TMO_W-1:0] tmo_q,
  output logic [DW-1:0]    rdata_q,
  output logic [DW-1:0]    host_rdata
);

  logic wr_wdata, wr_tmo;

  assign wr_wdata = host_we && !busy && (host_sel == SEL_WDATA);
  assign wr_tmo   = host_we && !busy && (host_sel == SEL_TMO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      tmo_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_wdata)   wdata_q <= host_wdata;
      if (wr_tmo)     tmo_q   <= host_wdata[TMO_W-1:0];
      if (rd_capture) rdata_q <= rd_value;
    end
  end

  always_comb begin
    unique case (host_sel)
      SEL_CTRL:  host_rdata = ctrl_rb;
      SEL_WDATA: host_rdata = wdata_q;
      SEL_TMO:   host_rdata = DW'(tmo_q);
      default:   host_rdata = rdata_q;
    endcase
  end

  // R9: configuration is frozen while a transaction runs
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wdata_q) && $stable(tmo_q));

  // R5: read data changes only on a capture
  p_rd_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_capture |=> $stable(rdata_q));

endmodule

// File: rtl/mbm_sequencer.sv
module mbm_sequencer
  import mbm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [DW-1:0] cmd_word,
  input  logic          ack,
  input  logic          err,
  input  logic          expire,
  output logic          busy,
  output logic          req,
  output mbm_cmd_t      cmd_q,
  output logic          flag_to,
  output logic          flag_serr,
  output logic          launch,
  output logic          resp,
  output logic          rd_capture
);

  mbm_state_t state_q;

  assign busy       = (state_q == ST_WAIT);
  assign req        = busy;
  assign launch     = cmd_wr && cmd_word[B_START] && !busy;
  assign resp       = busy && (ack || err);
  assign rd_capture = resp && !err && !cmd_q.we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cmd_q     <= '0;
      flag_to   <= 1'b0;
      flag_serr <= 1'b0;
    end else if (launch) begin
      state_q   <= ST_WAIT;
      cmd_q     <= cmd_decode(cmd_word);
      flag_to   <= 1'b0;
      flag_serr <= 1'b0;
    end else if (resp) begin
      state_q   <= ST_IDLE;
      flag_serr <= err;
    end else if (expire) begin
      state_q   <= ST_IDLE;
      flag_to   <= 1'b1;
    end
  end

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> req && busy);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req && !resp && !expire |=> req && $stable(cmd_q));

  p_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resp |=> !busy && !req);

  p_serr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp && err |=> flag_serr && !flag_to);

  p_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_to && !req);

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_wr && !resp && !expire |=> busy && $stable(cmd_q));

  p_flags_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !launch |=> $stable(flag_to) && $stable(flag_serr));

  p_launch_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !flag_to && !flag_serr);

endmodule

// File: rtl/mbm_master.sv
module mbm_master
  import mbm_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [3:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        bus_req,
  output logic        bus_we,
  output logic [7:0]  bus_addr,
  output logic [11:0] bus_off,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic        bus_err,
  input  logic [31:0] bus_rdata
);

  logic [1:0]       sel;
  logic             cmd_wr;
  logic             busy, flag_to, flag_serr, launch, resp, rd_capture, expire;
  mbm_cmd_t         cmd_q;
  logic [DW-1:0]    wdata_q, rdata_q, ctrl_rb;
  logic [TMO_W-1:0] tmo_q;

  assign sel     = reg_sel(host_addr);
  assign cmd_wr  = host_we && (sel == SEL_CTRL);
  assign ctrl_rb = ctrl_word(busy, flag_to, flag_serr, busy, cmd_q);

  mbm_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .cmd_word   (host_wdata),
    .ack        (bus_ack),
    .err        (bus_err),
    .expire     (expire),
    .busy       (busy),
    .req        (bus_req),
    .cmd_q      (cmd_q),
    .flag_to    (flag_to),
    .flag_serr  (flag_serr),
    .launch     (launch),
    .resp       (resp),
    .rd_capture (rd_capture)
  );

  mbm_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (launch),
    .tmo_val (tmo_q),
    .run     (busy),
    .resp    (resp),
    .expire  (expire)
  );

  mbm_regs #(.TMO_W(TMO_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_sel   (sel),
    .host_wdata (host_wdata),
    .busy       (busy),
    .rd_capture (rd_capture),
    .rd_value   (bus_rdata),
    .ctrl_rb    (ctrl_rb),
    .wdata_q    (wdata_q),
    .tmo_q      (tmo_q),
    .rdata_q    (rdata_q),
    .host_rdata (host_rdata)
  );

  assign bus_we    = cmd_q.we;
  assign bus_addr  = cmd_q.sa;
  assign bus_off   = cmd_q.off;
  assign bus_wdata = wdata_q;

  // R1: nothing is requested straight out of reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !bus_req);

  // R3: outgoing data is steady while the request waits
  p_wdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !resp && !expire |=> $stable(bus_wdata));

endmodule

// File: tb/sim_mbm_master.sv
module sim_mbm_master;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CTRL = 4'h0, A_WD = 4'h4, A_TMO = 4'h8, A_RD = 4'hC;

  logic        clk = 0, rst_n = 0;
  logic        host_we = 0;
  logic [3:0]  host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic        bus_req, bus_we, bus_ack = 0, bus_err = 0;
  logic [7:0]  bus_addr;
  logic [11:0] bus_off;
  logic [31:0] bus_wdata, bus_rdata = 0;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_rd = 0;

  mbm_master u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] slv_data(input logic [7:0] sa, input logic [11:0] off);
    return {sa, 4'h9, off, 8'h3C} ^ 32'h0F0F_0000;
  endfunction

  function automatic logic [31:0] exp_ctrl(input bit to, input bit se, input bit we,
                                           input logic [7:0] sa, input logic [11:0] off);
    return (32'(to) << 30) | (32'(se) << 29) | (32'(we) << 20) | (32'(sa) << 12) | 32'(off);
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, expv);
    end
  endtask

  task automatic hw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1;
    @(posedge clk); #1;
    host_we = 0; host_addr = A_CTRL;
  endtask

  task automatic hr(input logic [3:0] a, output logic [31:0] v);
    host_addr = a; #1; v = host_rdata; host_addr = A_CTRL;
  endtask

  // kind: 0 ack, 1 err, 2 no answer
  task automatic run_txn(input bit we, input logic [7:0] sa, input int byte_off,
                         input logic [31:0] wd, input int dly, input int kind, input int tmo);
    logic [11:0] off;
    logic [31:0] v;
    int cyc;
    bit moved, ok, to, se;
    off = 12'((byte_off / 4) & 12'hFFF);
    hw(A_TMO, 32'(tmo));
    hw(A_WD, wd);
    hw(A_CTRL, 32'h8000_0000 | (32'(we) << 20) | (32'(sa) << 12) | 32'(off));
    cyc = 0; moved = 0;
    forever begin
      @(negedge clk);
      if (!bus_req || cyc > 500) break;
      cyc++;
      if (cyc == 1) begin
        chk("R2 bus_we", 32'(bus_we), 32'(we));
        chk("R2 bus_addr", 32'(bus_addr), 32'(sa));
        chk("R2 bus_off", 32'(bus_off), 32'(off));
        chk("R2 bus_wdata", bus_wdata, wd);
        hr(A_CTRL, v);
        chk("R2 start/busy", 32'(v[31:28]), 32'h9);
      end else if (bus_we !== we || bus_addr !== sa || bus_off !== off || bus_wdata !== wd)
        moved = 1;
      bus_ack = (kind == 0 && cyc == dly + 1);
      bus_err = (kind == 1 && cyc == dly + 1);
      bus_rdata = bus_ack ? slv_data(sa, off) : 32'hBAD0_BAD0;
    end
    bus_ack = 0; bus_err = 0;
    ok = (kind != 2) && (tmo == 0 || dly + 1 <= tmo);
    se = ok && kind == 1;
    to = !ok;
    chk("R3 fields steady", 32'(moved), 0);
    chk(to ? "R7 request length" : "R4 request length", 32'(cyc), 32'(ok ? dly + 1 : tmo));
    if (ok && kind == 0 && !we) exp_rd = slv_data(sa, off);
    hr(A_CTRL, v);
    chk(to ? "R7 ctrl word" : (se ? "R6 ctrl word" : "R4 ctrl word"), v, exp_ctrl(to, se, we, sa, off));
    hr(A_RD, v);
    chk(we || !ok ? "R5/R6 read data kept" : "R5 read data", v, exp_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=finish", 200000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 bus_req", 32'(bus_req), 0);
    hr(A_CTRL, v); chk("R1 ctrl", v, 0);
    hr(A_WD, v);   chk("R1 wdata", v, 0);
    hr(A_TMO, v);  chk("R1 tmo", v, 0);
    hr(A_RD, v);   chk("R1 rdata", v, 0);

    // R12 readback, host_addr[1:0] undecoded (R11)
    hw(4'h5, 32'hCAFE_F00D); hr(A_WD, v); chk("R12 wdata readback", v, 32'hCAFE_F00D);
    hw(A_TMO, 32'h0001_0023); hr(A_TMO, v); chk("R12 tmo readback", v, 32'h0000_0023);
    hw(A_RD, 32'hDEAD_BEEF); hr(A_RD, v); chk("R11 rdata write ignored", v, 0);

    // R2 R4 R5 R8: sweep direction, slave address, delay, timeout
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++)
        for (int d = 0; d < 4; d++)
          for (int t = 0; t < 3; t++)
            run_txn(w[0], 8'(s * 85), s * 1024 + d * 4 + 3, 32'h1000_0000 + 32'(s * 16 + d),
                    d, 0, t * 3);

    // R6 error answers
    for (int d = 0; d < 3; d++) run_txn(d[0], 8'(16 * d + 1), 64 * d, 32'h55AA_0000, d, 1, 0);

    // R7 timeouts, including answer on/after the last allowed cycle
    for (int t = 1; t < 7; t++) run_txn(1'b0, 8'(t), t * 8, 0, 0, 2, t);
    run_txn(1'b0, 8'h21, 40, 0, 3, 0, 4);
    run_txn(1'b0, 8'h22, 44, 0, 4, 0, 4);

    // R10 R11: flag sticky across non-launch command, cleared by next launch
    run_txn(1'b1, 8'h7E, 12, 32'h0BAD_0001, 1, 1, 0);
    hw(A_CTRL, 32'h0012_3456);
    @(negedge clk);
    chk("R11 no launch", 32'(bus_req), 0);
    hr(A_CTRL, v); chk("R10 serr sticky", v, exp_ctrl(0, 1, 1, 8'h7E, 12'd3));
    run_txn(1'b1, 8'h7F, 16, 32'h600D_0002, 0, 0, 0);

    // R9 R8: busy ignores host writes; zero timeout waits indefinitely
    hw(A_TMO, 0);
    hw(A_WD, 32'h1111_1111);
    hw(A_CTRL, 32'h8010_0000 | (32'h33 << 12) | 32'h10);
    hw(A_CTRL, 32'h8000_0000 | (32'h44 << 12) | 32'h20);
    hw(A_WD, 32'h2222_2222);
    hw(A_TMO, 3);
    @(negedge clk);
    chk("R9 addr held", 32'(bus_addr), 32'h33);
    chk("R9 dir held", 32'(bus_we), 1);
    chk("R9 wdata held", bus_wdata, 32'h1111_1111);
    hr(A_WD, v);  chk("R9 wdata reg", v, 32'h1111_1111);
    hr(A_TMO, v); chk("R9 tmo reg", v, 0);
    repeat (40) @(negedge clk);
    chk("R8 still waiting", 32'(bus_req), 1);
    bus_ack = 1;
    @(negedge clk);
    bus_ack = 0;
    hr(A_CTRL, v); chk("R4 done after ack", v, exp_ctrl(0, 0, 1, 8'h33, 12'h10));
    chk("R4 req low", 32'(bus_req), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule